// File: doc/BRIEF.md
# Interrupt Enable, Pending and Active State Bank

This block keeps three state bits for each of 128 interrupt lines: enabled, pending and active. Software reaches the state through a small register bus. The bus has a word address, a write strobe, write data and combinational read data. The enable state and the pending state each appear under two addresses. One address sets bits and the other clears them. Both addresses read back the same underlying vector, and the active state can only be read. Each bus word covers 32 lines, so line `n` sits in word `n/32` at bit `n%32`.

Hardware interrupt inputs are sampled every cycle. A rising edge on a line makes that line pending, whether or not the line is enabled. A fixed-priority selector looks at every line that is enabled, pending and not yet active, and reports the lowest-numbered one as the activation request. When the consumer pulses `ackPulse`, the requested line moves from pending to active. A later completion input, which names a line, retires that line's active state.

Top module: `irq_state_bank`

## Requirements
- R1: The bus address is `{group[2:0], word[1:0]}`. Line `n` is bit `n%32` of word `n/32`. Group codes are: 0 enable-set, 1 enable-clear, 2 pending-set, 3 pending-clear, 4 active.
- R2: A write to group 0 enables each line whose data bit is 1. Data bits that are 0 leave the enable state unchanged.
- R3: A write to group 1 disables each line whose data bit is 1, and data bits that are 0 have no effect. Reads of group 0 and of group 1 both return the enable state.
- R4: Writes to group 2 set pending bits and writes to group 3 clear them, in both cases only where the data bit is 1. Reads of either group return the pending state.
- R5: A 0-to-1 transition of `irqIn[n]` sets pending bit `n` in the cycle after the clock edge that samples it, even when line `n` is disabled. An input that stays high does not set the bit again after it has been cleared.
- R6: A line that is pending but disabled never raises `reqValid` for that line.
- R7: `reqValid` is 1 exactly when some line is enabled, pending and not active. `reqLine` then gives the lowest-numbered such line.
- R8: When `ackPulse` is 1 while `reqValid` is 1, the requested line's pending bit clears and its active bit sets at the same clock edge.
- R9: When `doneValid` is 1, the active bit of line `doneLine` clears. Writes to group 4 have no effect on any state.
- R10: If a rising input edge and a pending-clear write hit the same bit in one cycle, the bit ends up set.
- R11: After reset, all enable, pending and active bits are 0 and `reqValid` is 0. Reads of groups 5 to 7 return 0, and writes to those groups change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Group code and word index |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data, one bit per line |
| busRdata | output | 32 | Read data for the addressed word |
| irqIn | input | 128 | Interrupt input levels |
| ackPulse | input | 1 | Takes the currently requested line |
| doneValid | input | 1 | Completion strobe |
| doneLine | input | 7 | Line whose active bit is retired |
| reqValid | output | 1 | An eligible line exists |
| reqLine | output | 7 | Lowest-numbered eligible line |

## Verification
The checker watches four rules on every cycle:
- A reported request always names a line that is enabled, pending and not active.
- Every rising input edge has become pending one edge later.
- An acknowledged line moves from pending to active.
- The enable and active vectors change only under a bus write, an acknowledge or a completion.

Other behaviours are shown only by the bench's scenarios, which compare read-back words against a model:
- the address decoding;
- that zero data bits have no effect;
- that set and clear aliases read the same state;
- that active-word writes and unused groups are ignored;
- the lowest-index choice among several eligible lines.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  typedef enum logic [2:0] {
    GRP_EN_SET = 3'd0,
    GRP_EN_CLR = 3'd1,
    GRP_PD_SET = 3'd2,
    GRP_PD_CLR = 3'd3,
    GRP_ACT    = 3'd4
  } grpSel_e;

  localparam int GRP_W = 3;

  typedef struct packed {
    logic enSet;
    logic enClr;
    logic pdSet;
    logic pdClr;
    logic ackTake;
    logic doneClr;
  } bankStrobe_t;

endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int WORD_IDX_W = 2,
  localparam int ADDR_W = GRP_W + WORD_IDX_W
) (
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWe,
  input  logic                  ackPulse,
  input  logic                  reqValid,
  input  logic                  doneValid,
  output bankStrobe_t           strb,
  output logic [GRP_W-1:0]      grpSel,
  output logic [WORD_IDX_W-1:0] wordIdx
);

  assign grpSel  = busAddr[ADDR_W-1 -: GRP_W];
  assign wordIdx = busAddr[WORD_IDX_W-1:0];

  always_comb begin
    strb         = '0;
    strb.enSet   = busWe && (grpSel == GRP_EN_SET);
    strb.enClr   = busWe && (grpSel == GRP_EN_CLR);
    strb.pdSet   = busWe && (grpSel == GRP_PD_SET);
    strb.pdClr   = busWe && (grpSel == GRP_PD_CLR);
    strb.ackTake = ackPulse && reqValid;
    strb.doneClr = doneValid;
  end

endmodule

// File: rtl/irq_bank_datapath.sv
module irq_bank_datapath
  import irq_bank_pkg::*;
#(
  parameter int NUM_LINES = 128,
  parameter int WORD_W    = 32,
  localparam int NUM_WORDS  = NUM_LINES / WORD_W,
  localparam int WORD_IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int LINE_W     = $clog2(NUM_LINES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bankStrobe_t           strb,
  input  logic [GRP_W-1:0]      grpSel,
  input  logic [WORD_IDX_W-1:0] wordIdx,
  input  logic [WORD_W-1:0]     busWdata,
  input  logic [NUM_LINES-1:0]  irqIn,
  input  logic [LINE_W-1:0]     reqLine,
  input  logic [LINE_W-1:0]     doneLine,
  output logic [NUM_LINES-1:0]  enableVec,
  output logic [NUM_LINES-1:0]  pendVec,
  output logic [NUM_LINES-1:0]  activeVec,
  output logic [WORD_W-1:0]     busRdata
);

  logic [NUM_LINES-1:0] enQ, pdQ, actQ, irqPrevQ;
  logic [NUM_LINES-1:0] wideData, riseVec, ackMask, doneMask;
  logic [NUM_LINES-1:0] enNext, pdNext, actNext;
  localparam logic [NUM_LINES-1:0] ONE_HOT0 = {{(NUM_LINES-1){1'b0}}, 1'b1};

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign wideData[w*WORD_W +: WORD_W] =
      (wordIdx == WORD_IDX_W'(w)) ? busWdata : '0;
  end

  assign riseVec  = irqIn & ~irqPrevQ;
  assign ackMask  = strb.ackTake ? (ONE_HOT0 << reqLine)  : '0;
  assign doneMask = strb.doneClr ? (ONE_HOT0 << doneLine) : '0;

  always_comb begin
    enNext = enQ;
    if (strb.enClr) enNext = enNext & ~wideData;
    if (strb.enSet) enNext = enNext | wideData;

    pdNext = pdQ & ~ackMask;
    if (strb.pdClr) pdNext = pdNext & ~wideData;
    if (strb.pdSet) pdNext = pdNext | wideData;
    pdNext = pdNext | riseVec;

    actNext = (actQ & ~doneMask) | ackMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ      <= '0;
      pdQ      <= '0;
      actQ     <= '0;
      irqPrevQ <= '0;
    end else begin
      enQ      <= enNext;
      pdQ      <= pdNext;
      actQ     <= actNext;
      irqPrevQ <= irqIn;
    end
  end

  always_comb begin
    unique case (grpSel)
      GRP_EN_SET, GRP_EN_CLR: busRdata = enQ[wordIdx*WORD_W +: WORD_W];
      GRP_PD_SET, GRP_PD_CLR: busRdata = pdQ[wordIdx*WORD_W +: WORD_W];
      GRP_ACT:                busRdata = actQ[wordIdx*WORD_W +: WORD_W];
      default:                busRdata = '0;
    endcase
  end

  assign enableVec = enQ;
  assign pendVec   = pdQ;
  assign activeVec = actQ;

endmodule

// File: rtl/irq_bank_selector.sv
module irq_bank_selector #(
  parameter int NUM_LINES = 128,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] enableVec,
  input  logic [NUM_LINES-1:0] pendVec,
  input  logic [NUM_LINES-1:0] activeVec,
  output logic                 reqValid,
  output logic [LINE_W-1:0]    reqLine
);

  logic [NUM_LINES-1:0] candVec;
  assign candVec = enableVec & pendVec & ~activeVec;

  always_comb begin
    reqValid = 1'b0;
    reqLine  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (candVec[i]) begin
        reqValid = 1'b1;
        reqLine  = LINE_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_LINES = 128,
  parameter int WORD_W    = 32,
  localparam int NUM_WORDS  = NUM_LINES / WORD_W,
  localparam int WORD_IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W     = GRP_W + WORD_IDX_W,
  localparam int LINE_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [WORD_W-1:0]    busWdata,
  output logic [WORD_W-1:0]    busRdata,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 ackPulse,
  input  logic                 doneValid,
  input  logic [LINE_W-1:0]    doneLine,
  output logic                 reqValid,
  output logic [LINE_W-1:0]    reqLine
);

  bankStrobe_t           strb;
  logic [GRP_W-1:0]      grpSel;
  logic [WORD_IDX_W-1:0] wordIdx;
  logic [NUM_LINES-1:0]  enableVec, pendVec, activeVec;

  irq_bank_ctrl #(.WORD_IDX_W(WORD_IDX_W)) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .ackPulse(ackPulse),
    .reqValid(reqValid), .doneValid(doneValid),
    .strb(strb), .grpSel(grpSel), .wordIdx(wordIdx)
  );

  irq_bank_datapath #(.NUM_LINES(NUM_LINES), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .grpSel(grpSel),
    .wordIdx(wordIdx), .busWdata(busWdata), .irqIn(irqIn),
    .reqLine(reqLine), .doneLine(doneLine),
    .enableVec(enableVec), .pendVec(pendVec), .activeVec(activeVec),
    .busRdata(busRdata)
  );

  irq_bank_selector #(.NUM_LINES(NUM_LINES)) u_sel (
    .enableVec(enableVec), .pendVec(pendVec), .activeVec(activeVec),
    .reqValid(reqValid), .reqLine(reqLine)
  );

endmodule

// File: rtl/irq_state_bank_chk.sv
module irq_state_bank_chk #(
  parameter int NUM_LINES = 128,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] irqIn,
  input logic                 busWe,
  input logic                 ackPulse,
  input logic                 doneValid,
  input logic [LINE_W-1:0]    doneLine,
  input logic                 reqValid,
  input logic [LINE_W-1:0]    reqLine,
  input logic [NUM_LINES-1:0] enableVec,
  input logic [NUM_LINES-1:0] pendVec,
  input logic [NUM_LINES-1:0] activeVec
);

  logic [NUM_LINES-1:0] prevSeenQ;
  always_ff @(posedge clk) begin
    if (!rstN) prevSeenQ <= '0;
    else       prevSeenQ <= irqIn;
  end

  // R6 and R7: a request always names an eligible line
  p_req_eligible_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (enableVec[reqLine] && pendVec[reqLine] && !activeVec[reqLine]));

  // R5: every rising edge is pending one edge later
  p_rise_pending_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((irqIn & ~prevSeenQ) != '0) |=>
      ((($past(irqIn) & ~$past(prevSeenQ)) & ~pendVec) == '0));

  // R8: acknowledge moves the requested line from pending to active
  p_ack_move_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ackPulse && !irqIn[reqLine] && !busWe) |=>
      (activeVec[$past(reqLine)] && !pendVec[$past(reqLine)]));

  // R9: completion clears the named active bit
  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !(ackPulse && reqValid && reqLine == doneLine)) |=>
      !activeVec[$past(doneLine)]);

  // R9: active state changes only under acknowledge or completion
  p_active_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!ackPulse && !doneValid) |=> $stable(activeVec));

  // R2: enable state changes only under a bus write
  p_enable_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> $stable(enableVec));

endmodule

bind irq_state_bank irq_state_bank_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rstN(rstN), .irqIn(irqIn), .busWe(busWe),
  .ackPulse(ackPulse), .doneValid(doneValid), .doneLine(doneLine),
  .reqValid(reqValid), .reqLine(reqLine), .enableVec(enableVec),
  .pendVec(pendVec), .activeVec(activeVec)
);

// File: tb/irq_state_bank_bench.sv
module irq_state_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 128;

  logic         clk = 1'b0;
  logic         rstN;
  logic [4:0]   busAddr;
  logic         busWe;
  logic [31:0]  busWdata;
  logic [31:0]  busRdata;
  logic [NL-1:0] irqIn;
  logic         ackPulse;
  logic         doneValid;
  logic [6:0]   doneLine;
  logic         reqValid;
  logic [6:0]   reqLine;

  int total = 0;
  int bad = 0;

  logic [NL-1:0] mEn, mPd, mAct, mPrev;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_state_bank u_irq_state_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn),
    .ackPulse(ackPulse), .doneValid(doneValid), .doneLine(doneLine),
    .reqValid(reqValid), .reqLine(reqLine)
  );

  function automatic int modelSel();
    for (int i = 0; i < NL; i++)
      if (mEn[i] && mPd[i] && !mAct[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] modelWord(input int grp, input int word);
    case (grp)
      0, 1: return mEn[word*32 +: 32];
      2, 3: return mPd[word*32 +: 32];
      4:    return mAct[word*32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int grp, input int word, output logic [31:0] data);
    busWe   = 1'b0;
    busAddr = {3'(grp), 2'(word)};
    #1;
    data = busRdata;
  endtask

  task automatic wr(input int grp, input int word, input logic [31:0] data);
    busWe = 1'b1;
    busAddr = {3'(grp), 2'(word)};
    busWdata = data;
  endtask

  task automatic tick();
    logic [NL-1:0] wide, rise, ackM, doneM, nEn, nPd, nAct;
    int s;
    int grp;
    grp  = int'(busAddr[4:2]);
    wide = {96'h0, busWdata} << (32 * busAddr[1:0]);
    rise = irqIn & ~mPrev;
    s    = modelSel();
    ackM = (ackPulse && s >= 0) ? ({{(NL-1){1'b0}}, 1'b1} << s) : '0;
    doneM = doneValid ? ({{(NL-1){1'b0}}, 1'b1} << doneLine) : '0;
    nEn = mEn;
    if (busWe && grp == 1) nEn = nEn & ~wide;
    if (busWe && grp == 0) nEn = nEn | wide;
    nPd = mPd & ~ackM;
    if (busWe && grp == 3) nPd = nPd & ~wide;
    if (busWe && grp == 2) nPd = nPd | wide;
    nPd = nPd | rise;
    nAct = (mAct & ~doneM) | ackM;
    @(posedge clk);
    mEn = nEn; mPd = nPd; mAct = nAct; mPrev = irqIn;
    @(negedge clk);
    busWe = 1'b0; ackPulse = 1'b0; doneValid = 1'b0;
  endtask

  task automatic chkReq(input string tag);
    int s;
    s = modelSel();
    chk({tag, " reqValid"}, 32'(reqValid), 32'(s >= 0));
    if (s >= 0) chk({tag, " reqLine"}, 32'(reqLine), 32'(s));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    process::self().srandom(32'd1234);
    rstN = 1'b0; busAddr = '0; busWe = 1'b0; busWdata = '0; irqIn = '0;
    ackPulse = 1'b0; doneValid = 1'b0; doneLine = '0;
    mEn = '0; mPd = '0; mAct = '0; mPrev = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R11: reset state, all groups read zero
    chk("R11 reset reqValid", 32'(reqValid), 32'h0);
    for (int g = 0; g < 8; g++)
      for (int w = 0; w < 4; w++) begin
        rd(g, w, d);
        chk("R11 reset read", d, 32'h0);
      end

    // R2 and R1: enable lines 32 and 34 through word 1
    wr(0, 1, 32'h5); tick();
    rd(1, 1, d); chk("R3 enable read via clear alias", d, 32'h5);
    rd(0, 1, d); chk("R1 word1 enable", d, 32'h5);
    rd(0, 0, d); chk("R1 word0 untouched", d, 32'h0);
    wr(0, 1, 32'h0); tick();
    rd(0, 1, d); chk("R2 zero write no effect", d, 32'h5);
    wr(1, 1, 32'h1); tick();
    rd(0, 1, d); chk("R3 clear enable", d, 32'h4);

    // R5 and R6: disabled line 3 rises
    irqIn[3] = 1'b1; tick();
    rd(2, 0, d); chk("R5 disabled rise pends", d, 32'h8);
    chk("R6 disabled no request", 32'(reqValid), 32'h0);
    irqIn[34] = 1'b1; tick();
    chk("R7 single eligible", 32'(reqLine), 32'd34);
    wr(0, 0, 32'h8); tick();
    chk("R7 lowest wins valid", 32'(reqValid), 32'h1);
    chk("R7 lowest wins line", 32'(reqLine), 32'd3);

    // R8: acknowledge
    ackPulse = 1'b1; tick();
    rd(3, 0, d); chk("R8 pending cleared", d, 32'h0);
    rd(4, 0, d); chk("R8 active set", d, 32'h8);
    chk("R8 next request", 32'(reqLine), 32'd34);

    // R9: active writes ignored, completion clears
    wr(4, 0, 32'h0); tick();
    rd(4, 0, d); chk("R9 active write ignored", d, 32'h8);
    doneValid = 1'b1; doneLine = 7'd3; tick();
    rd(4, 0, d); chk("R9 done clears", d, 32'h0);

    // R5: held level does not re-pend
    wr(2, 0, 32'h10); tick();
    rd(3, 0, d); chk("R4 pending set", d, 32'h10);
    wr(3, 0, 32'h10); tick();
    rd(2, 0, d); chk("R4 pending clear", d, 32'h0);
    tick();
    rd(2, 0, d); chk("R5 held level no repend", d, 32'h0);

    // R10: rise beats bus clear
    irqIn[3] = 1'b0; tick();
    irqIn[3] = 1'b1; wr(3, 0, 32'h8); tick();
    rd(2, 0, d); chk("R10 rise beats clear", d, 32'h8);

    // R11: unused group ignored
    wr(5, 0, 32'hFFFF_FFFF); tick();
    rd(5, 0, d); chk("R11 unused group read", d, 32'h0);
    rd(0, 0, d); chk("R11 unused group no effect", d, modelWord(0, 0));

    // Random phase, R1 to R10 against the model
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(1, 0) == 1) irqIn[$urandom_range(NL-1, 0)] ^= 1'b1;
      if ($urandom_range(2, 0) == 0)
        wr(int'($urandom_range(5, 0)), int'($urandom_range(3, 0)), $urandom() & $urandom());
      ackPulse = ($urandom_range(3, 0) == 0);
      if ($urandom_range(3, 0) == 0 && mAct != '0) begin
        int st;
        st = int'($urandom_range(NL-1, 0));
        for (int k = 0; k < NL; k++)
          if (mAct[(st + k) % NL]) begin
            doneLine = 7'((st + k) % NL);
            break;
          end
        doneValid = 1'b1;
      end
      tick();
      chkReq("R7 random");
      begin
        int g, w;
        g = int'($urandom_range(7, 0));
        w = int'($urandom_range(3, 0));
        rd(g, w, d);
        chk("R4 random readback", d, modelWord(g, w));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule